// File: doc/BRIEF.md
# Class-Split Dual Instruction Issuer

The issuer sits between instruction fetch and the execution units of an in-order pipeline. Fetch hands it an aligned pair of instructions each cycle. Every instruction carries a class bit that was worked out when the cache line was filled, so no decoding happens here. There are two classes: floating-point ALU, and everything else. The block sends at most one instruction of each class per cycle. Integer-class instructions go out on the integer issue port and floating-point ALU instructions go out on the floating-point port. Program order is kept throughout.

Each instruction also names the long-latency unit it needs, if any: the integer multiply/divide unit or the floating-point divide/square-root unit. If that unit reports busy, the instruction waits. Every instruction younger than it waits too. There is no reordering and no speculation; the pipeline simply slips.

While any instruction of the current pair is still unissued, the block raises a stall to fetch, and fetch must keep presenting the same pair. The block remembers which slots of the held pair have already gone out, so none of them issues twice. A pair is consumed on the first clock edge at which the stall is low.

Top module: `dual_class_issuer`

## Requirements
- R1: Slot 0 is the older instruction and slot 1 the younger. A class bit of 1 marks a floating-point ALU instruction and 0 marks any other instruction. Class-1 instructions leave only on the fp port and class-0 only on the int port. Each port reports the source slot index and that slot's opcode.
- R2: A valid pair whose two slots have different classes, in either order, issues both slots in the same cycle when no resource blocks them.
- R3: When both slots have the same class, only slot 0 issues in the first cycle. Slot 1 issues in the following cycle, provided nothing blocks it.
- R4: If slot 0 is pending and does not issue, slot 1 does not issue in that cycle, even when its class port and its unit are free.
- R5: Each slot has a 2-bit resource code in the fch_res field, with slot 0 in bits 1:0 and slot 1 in bits 3:2. Code 1 is the integer multiply/divide unit and code 2 is the floating-point divide/square-root unit. Codes 0 and 3 mean no unit. An instruction whose unit's busy input is high does not issue.
- R6: When both slots name the same unit (code 1 or code 2), only slot 0 can issue in a given cycle. Slot 1 waits at least until the next cycle.
- R7: fch_stall is high in a cycle exactly when some valid slot of the presented pair is still unissued at the end of that cycle. The pair is consumed at a clock edge where fch_stall is low.
- R8: A slot that has issued while the pair is held is not issued again in a later cycle of the same hold.
- R9: A pair with only one valid slot issues that slot alone. A pair with no valid slot issues nothing and leaves fch_stall low.
- R10: While rst_n is low at a clock edge, nothing issues and fch_stall is high. Once reset is released, the presented pair is treated as fresh, with no slot recorded as issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fch_vld | input | 2 | Per-slot valid bits of the fetched pair |
| fch_cls | input | 2 | Per-slot class bit: 1 means floating-point ALU |
| fch_res | input | 4 | Per-slot 2-bit resource code, slot 0 in the low bits |
| fch_op | input | 2*OP_W | Per-slot opcode, slot 0 in the low bits |
| imd_busy | input | 1 | Integer multiply/divide unit busy |
| fdv_busy | input | 1 | Floating-point divide/square-root unit busy |
| int_vld | output | 1 | An instruction is issued on the integer port |
| int_slot | output | 1 | Source slot of the integer-port instruction |
| int_op | output | OP_W | Opcode on the integer port |
| fp_vld | output | 1 | An instruction is issued on the floating-point port |
| fp_slot | output | 1 | Source slot of the floating-point-port instruction |
| fp_op | output | OP_W | Opcode on the floating-point port |
| fch_stall | output | 1 | Fetch must hold the current pair |

## Verification
The assertions take for granted that fetch obeys the stall: while fch_stall is high, the pair's valid, class, resource and opcode fields do not change from one cycle to the next. Without this, the no-reissue and program-order properties would compare unrelated pairs. The bench drives a new pair only after a cycle in which its own model predicts a low stall, and it otherwise repeats the held pair. The busy inputs are treated as free-running: they may change in any cycle, including in the middle of a hold.

// File: rtl/dci_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the class-split dual issuer.
// Assumes: exactly two fetch slots; slot 0 is always the older one.
package dci_pkg;
    localparam int N_SLOT = 2;
    localparam int RES_W  = 2;
    localparam int N_UNIT = 2;

    localparam logic CLS_INT = 1'b0;
    localparam logic CLS_FP  = 1'b1;

    typedef enum logic [RES_W-1:0] {
        RES_NONE = 2'd0,
        RES_IMD  = 2'd1,
        RES_FDV  = 2'd2,
        RES_RSVD = 2'd3
    } res_e;
endpackage

// File: rtl/dci_unit_gate.sv
`timescale 1ns/1ps
// Per-slot resource gate: decodes the slot's resource code into a one-hot
// unit request and reports whether the requested unit is busy.
// Assumes: code 3 is reserved and requests no unit.
module dci_unit_gate
    import dci_pkg::*;
(
    input  logic [RES_W-1:0]  res,
    input  logic              imd_busy,
    input  logic              fdv_busy,
    output logic [N_UNIT-1:0] need,
    output logic              blk
);
    // Decode the request and compare it against the busy flags.
    always_comb begin
        need = '0;
        case (res_e'(res))
            RES_IMD: need[0] = 1'b1;
            RES_FDV: need[1] = 1'b1;
            default: need    = '0;
        endcase
        blk = (need[0] & imd_busy) | (need[1] & fdv_busy);
    end
endmodule

// File: rtl/dci_order_sel.sv
`timescale 1ns/1ps
// In-order selector: slot 0 issues when it is not blocked. Slot 1 issues only
// if slot 0 has nothing pending, or if slot 0 issues now with the other class
// and does not share a unit with slot 1.
// Assumes: pend already excludes slots issued earlier in the same hold.
module dci_order_sel
    import dci_pkg::*;
(
    input  logic [N_SLOT-1:0] pend,
    input  logic [N_SLOT-1:0] blk,
    input  logic [N_SLOT-1:0] cls,
    input  logic [N_UNIT-1:0] need0,
    input  logic [N_UNIT-1:0] need1,
    output logic [N_SLOT-1:0] issue
);
    logic ok0;
    logic pair_ok;

    // Decide the issue mask, oldest first.
    always_comb begin
        ok0      = pend[0] & ~blk[0];
        pair_ok  = ok0 & (cls[0] != cls[1]) & ~(|(need0 & need1));
        issue[0] = ok0;
        issue[1] = pend[1] & ~blk[1] & (~pend[0] | pair_ok);
    end
endmodule

// File: rtl/dci_port_mux.sv
`timescale 1ns/1ps
// Issue-port router: picks the issuing slot whose class matches PORT_CLS and
// presents its index and opcode.
// Assumes: the selector never issues two slots of one class in a cycle.
module dci_port_mux
    import dci_pkg::*;
#(
    parameter int   OP_W     = 32,
    parameter logic PORT_CLS = CLS_INT
) (
    input  logic [N_SLOT-1:0]      issue,
    input  logic [N_SLOT-1:0]      cls,
    input  logic [N_SLOT*OP_W-1:0] ops,
    output logic                   vld,
    output logic                   slot,
    output logic [OP_W-1:0]        op
);
    logic sel0;
    logic sel1;

    // Route the matching slot onto the port.
    always_comb begin
        sel0 = issue[0] & (cls[0] == PORT_CLS);
        sel1 = issue[1] & (cls[1] == PORT_CLS);
        vld  = sel0 | sel1;
        slot = sel1 & ~sel0;
        if (sel0)      op = ops[OP_W-1:0];
        else if (sel1) op = ops[2*OP_W-1:OP_W];
        else           op = '0;
    end
endmodule

// File: rtl/dual_class_issuer.sv
`timescale 1ns/1ps
// Class-split dual issuer. Issues at most one integer-class and one FP-ALU
// instruction per cycle from a fetched pair, in program order. A slot waits
// while its long-latency unit is busy, and everything younger waits with it.
// Assumes: fetch keeps the pair unchanged while fch_stall is high.
module dual_class_issuer
    import dci_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SLOT-1:0]        fch_vld,
    input  logic [N_SLOT-1:0]        fch_cls,
    input  logic [N_SLOT*RES_W-1:0]  fch_res,
    input  logic [N_SLOT*OP_W-1:0]   fch_op,
    input  logic                     imd_busy,
    input  logic                     fdv_busy,
    output logic                     int_vld,
    output logic                     int_slot,
    output logic [OP_W-1:0]          int_op,
    output logic                     fp_vld,
    output logic                     fp_slot,
    output logic [OP_W-1:0]          fp_op,
    output logic                     fch_stall
);
    logic [N_SLOT-1:0] done_q;
    logic [N_SLOT-1:0] pend;
    logic [N_SLOT-1:0] blk;
    logic [N_SLOT-1:0] issue_raw;
    logic [N_SLOT-1:0] issue;
    logic [N_UNIT-1:0] need [N_SLOT];

    // Slots still waiting in the presented pair.
    assign pend = fch_vld & ~done_q;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_gate
        dci_unit_gate u_gate (
            .res      (fch_res[s*RES_W +: RES_W]),
            .imd_busy (imd_busy),
            .fdv_busy (fdv_busy),
            .need     (need[s]),
            .blk      (blk[s])
        );
    end

    dci_order_sel u_sel (
        .pend  (pend),
        .blk   (blk),
        .cls   (fch_cls),
        .need0 (need[0]),
        .need1 (need[1]),
        .issue (issue_raw)
    );

    // Nothing leaves the block while reset is held.
    assign issue = issue_raw & {N_SLOT{rst_n}};

    // Stall while any pending slot is left over.
    assign fch_stall = ~rst_n | (|(pend & ~issue));

    // Record issued slots of a held pair; clear when the pair is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)         done_q <= '0;
        else if (fch_stall) done_q <= done_q | issue;
        else                done_q <= '0;
    end

    dci_port_mux #(.OP_W(OP_W), .PORT_CLS(CLS_INT)) u_int_port (
        .issue (issue),
        .cls   (fch_cls),
        .ops   (fch_op),
        .vld   (int_vld),
        .slot  (int_slot),
        .op    (int_op)
    );

    dci_port_mux #(.OP_W(OP_W), .PORT_CLS(CLS_FP)) u_fp_port (
        .issue (issue),
        .cls   (fch_cls),
        .ops   (fch_op),
        .vld   (fp_vld),
        .slot  (fp_slot),
        .op    (fp_op)
    );
endmodule

// File: rtl/dci_checker.sv
`timescale 1ns/1ps
// Property checker for the dual issuer, bound into every instance.
// Assumes: fetch holds the pair steady while fch_stall is high.
module dci_checker
    import dci_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_SLOT-1:0]       fch_vld,
    input logic [N_SLOT-1:0]       fch_cls,
    input logic [N_SLOT*RES_W-1:0] fch_res,
    input logic                    imd_busy,
    input logic                    fdv_busy,
    input logic                    int_vld,
    input logic                    int_slot,
    input logic                    fp_vld,
    input logic                    fp_slot,
    input logic                    fch_stall,
    input logic [N_SLOT-1:0]       done_q
);
    logic [RES_W-1:0] r_int;
    logic [RES_W-1:0] r_fp;
    logic             s0_out;
    logic             s0_wait;

    // Resource codes of the issued instructions and slot 0 progress.
    always_comb begin
        r_int   = int_slot ? fch_res[2*RES_W-1:RES_W] : fch_res[RES_W-1:0];
        r_fp    = fp_slot  ? fch_res[2*RES_W-1:RES_W] : fch_res[RES_W-1:0];
        s0_out  = (int_vld && !int_slot) || (fp_vld && !fp_slot);
        s0_wait = fch_vld[0] && !done_q[0];
    end

    AST_INT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        int_vld |-> (fch_cls[int_slot] == CLS_INT) && fch_vld[int_slot]); // R1
    AST_FP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        fp_vld |-> (fch_cls[fp_slot] == CLS_FP) && fch_vld[fp_slot]); // R1
    AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_vld && int_slot) || (fp_vld && fp_slot)) |-> (!s0_wait || s0_out)); // R4
    AST_IMD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_vld && r_int == RES_IMD) || (fp_vld && r_fp == RES_IMD)) |-> !imd_busy); // R5
    AST_FDV_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_vld && r_int == RES_FDV) || (fp_vld && r_fp == RES_FDV)) |-> !fdv_busy); // R5
    AST_UNIT_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
        (int_vld && fp_vld) |-> !(r_int == r_fp && (r_int == RES_IMD || r_int == RES_FDV))); // R6
    AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (fch_stall && int_vld) |=> !(int_vld && int_slot == $past(int_slot))); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!int_vld && !fp_vld && fch_stall)); // R10
endmodule

bind dual_class_issuer dci_checker u_dci_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fch_vld   (fch_vld),
    .fch_cls   (fch_cls),
    .fch_res   (fch_res),
    .imd_busy  (imd_busy),
    .fdv_busy  (fdv_busy),
    .int_vld   (int_vld),
    .int_slot  (int_slot),
    .fp_vld    (fp_vld),
    .fp_slot   (fp_slot),
    .fch_stall (fch_stall),
    .done_q    (done_q)
);

// File: tb/tb_dual_class_issuer.sv
`timescale 1ns/1ps
module tb_dual_class_issuer;
    localparam int OP_W = 32;
    localparam logic [OP_W-1:0] OP0 = 32'hA0A0_0000;
    localparam logic [OP_W-1:0] OP1 = 32'hB1B1_0001;

    // {vld[1:0], cls[1:0], res[3:0], imd, fdv, exp iv, is, fv, fs, stall}
    localparam int NV = 20;
    localparam logic [14:0] VEC [NV] = '{
        15'b11_10_0000_00_10110, // R1 R2 int then fp
        15'b11_01_0000_00_11100, // R2 fp then int
        15'b11_00_0000_00_10001, // R3 both int, older first
        15'b11_00_0000_00_11000, // R3 R8 younger next cycle
        15'b11_11_0000_00_00101, // R3 both fp
        15'b11_11_0000_00_00110, // R3 R8
        15'b11_10_0001_10_00001, // R4 R5 older waits on busy mul/div
        15'b11_10_0001_00_10110, // R5 unit free
        15'b11_10_1000_01_10001, // R5 younger waits on busy div/sqrt
        15'b11_10_1000_01_00001, // R8 older not reissued
        15'b11_10_1000_00_00110, // R5 R7 released
        15'b01_01_0000_00_00100, // R9 lone slot 0
        15'b10_00_0000_00_11000, // R9 lone slot 1
        15'b00_00_0000_00_00000, // R9 empty pair
        15'b11_10_0101_00_10001, // R6 shared unit
        15'b11_10_0101_10_00001, // R6 unit now busy
        15'b11_10_0101_00_00110, // R6 younger goes
        15'b11_10_1111_11_10110, // R5 reserved code ignores busy
        15'b11_01_0010_01_00001, // R4 older fp blocked
        15'b11_01_0010_00_11100  // R4 R7 both go
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          fch_vld = '0;
    logic [1:0]          fch_cls = '0;
    logic [3:0]          fch_res = '0;
    logic [2*OP_W-1:0]   fch_op = {OP1, OP0};
    logic                imd_busy = 1'b0;
    logic                fdv_busy = 1'b0;
    logic                int_vld, int_slot, fp_vld, fp_slot, fch_stall;
    logic [OP_W-1:0]     int_op, fp_op;
    int                  n_chk = 0;
    int                  n_bad = 0;
    logic                hold;
    logic [1:0]          mdone;
    logic [1:0]          miss;
    logic [4:0]          mexp;

    always #2.5 clk = ~clk;

    dual_class_issuer #(.OP_W(OP_W)) dut (
        .clk(clk), .rst_n(rst_n), .fch_vld(fch_vld), .fch_cls(fch_cls),
        .fch_res(fch_res), .fch_op(fch_op), .imd_busy(imd_busy),
        .fdv_busy(fdv_busy), .int_vld(int_vld), .int_slot(int_slot),
        .int_op(int_op), .fp_vld(fp_vld), .fp_slot(fp_slot), .fp_op(fp_op),
        .fch_stall(fch_stall)
    );

    // Outputs with slot fields masked when the port is idle.
    function automatic logic [4:0] observed();
        return {int_vld, int_vld & int_slot, fp_vld, fp_vld & fp_slot, fch_stall};
    endfunction

    function automatic logic [4:0] masked(input logic [4:0] e);
        return {e[4], e[4] & e[3], e[2], e[2] & e[1], e[0]};
    endfunction

    // Opcode on each active port must be the opcode of its slot (R1).
    function automatic logic ops_ok();
        logic ok = 1'b1;
        if (int_vld && int_op != (int_slot ? OP1 : OP0)) ok = 1'b0;
        if (fp_vld && fp_op != (fp_slot ? OP1 : OP0)) ok = 1'b0;
        return ok;
    endfunction

    task automatic check(input string req, input logic [4:0] exp);
        n_chk++;
        if (observed() != masked(exp) || !ops_ok()) begin
            n_bad++;
            $display("FAIL %s: got iv/is/fv/fs/st=%b ops_ok=%0b, expected %b",
                     req, observed(), ops_ok(), masked(exp));
        end
    endtask

    // Reference: walk pending slots oldest first, stop at the first that cannot go.
    function automatic logic [1:0] model(input logic [1:0] v, input logic [1:0] c,
                                         input logic [3:0] r, input logic mb,
                                         input logic fb, input logic [1:0] dn);
        logic [1:0] iss = '0;
        logic used_i = 1'b0, used_f = 1'b0, u_m = 1'b0, u_f = 1'b0, stop = 1'b0;
        for (int s = 0; s < 2; s++) begin
            logic [1:0] rc = r[2*s +: 2];
            logic nm = (rc == 2'd1);
            logic nf = (rc == 2'd2);
            if (v[s] && !dn[s] && !stop) begin
                if ((nm && (mb || u_m)) || (nf && (fb || u_f)) ||
                    (c[s] ? used_f : used_i)) begin
                    stop = 1'b1;
                end else begin
                    iss[s] = 1'b1;
                    if (c[s]) used_f = 1'b1; else used_i = 1'b1;
                    if (nm) u_m = 1'b1;
                    if (nf) u_f = 1'b1;
                end
            end
        end
        return iss;
    endfunction

    function automatic logic [4:0] to_exp(input logic [1:0] iss, input logic [1:0] c,
                                          input logic [1:0] v, input logic [1:0] dn);
        logic [4:0] e = '0;
        for (int s = 1; s >= 0; s--) begin
            if (iss[s] && !c[s]) begin e[4] = 1'b1; e[3] = s[0]; end
            if (iss[s] &&  c[s]) begin e[2] = 1'b1; e[1] = s[0]; end
        end
        e[0] = |(v & ~dn & ~iss);
        return e;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got no finish, expected end of run");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R10: during reset nothing issues and stall is high, even with a valid pair.
        @(negedge clk);
        fch_vld = 2'b11; fch_cls = 2'b10;
        #1 check("R10 reset quiet", 5'b00001);
        repeat (2) @(negedge clk);
        fch_vld = '0;
        rst_n = 1'b1;

        // Table walk: the pair is held in rows that follow a stalled row.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {fch_vld, fch_cls, fch_res, imd_busy, fdv_busy} = VEC[i][14:5];
            #1 check($sformatf("table row %0d", i), VEC[i][4:0]);
        end

        // Random in-order model comparison covering R1..R9.
        hold = 1'b0;
        mdone = '0;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (!hold) begin
                fch_vld = 2'($urandom);
                fch_cls = 2'($urandom);
                fch_res = 4'($urandom);
            end
            imd_busy = ($urandom % 3) == 0;
            fdv_busy = ($urandom % 3) == 0;
            miss = model(fch_vld, fch_cls, fch_res, imd_busy, fdv_busy, mdone);
            mexp = to_exp(miss, fch_cls, fch_vld, mdone);
            #1 check("R1-model R7 random", mexp);
            hold = mexp[0];
            mdone = hold ? (mdone | miss) : 2'b00;
        end

        // R10: a reset in the middle of a hold forgets the issued slots.
        @(negedge clk);
        fch_vld = '0; imd_busy = 1'b0; fdv_busy = 1'b0;
        #1 check("R9 flush", 5'b00000);
        @(negedge clk);
        fch_vld = 2'b11; fch_cls = 2'b00; fch_res = '0;
        #1 check("R3 before reset", 5'b10001);
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R10 reset in hold", 5'b00001);
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R10 fresh after reset", 5'b10001);
        @(negedge clk);
        #1 check("R3 R8 younger after reset", 5'b11000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule